// File: doc/BRIEF.md
# Operand Address Generator

This block works out where the operand of one instruction lives, for a small processor with an 8-bit accumulator and a 16-bit address space. The instruction fetch logic presents the addressing mode code, an optional prebyte, up to two bytes that follow the opcode, the two index registers and the address of the instruction's first byte. One cycle later the block returns the 16-bit operand address, a flag saying that the operand sits inside the instruction stream, the total instruction length in bytes, and an error flag.

The modes are: inherent (no operand address), immediate (the operand is the one or two bytes after the opcode), direct (one byte gives the low half of a page-zero address), extended (two bytes give a full address, high byte first), indexed (an unsigned byte offset added to an index register) and relative (a signed byte offset added to the address just past the instruction). A prebyte of 0x18 switches indexed addressing from the X register to the Y register; the prebytes 0x1A and 0xCD are accepted but keep X. Every accepted prebyte adds one byte to the length. All address sums wrap modulo 2^16.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset, and until the first accepted request, outValid, effAddr, instrLen, isImm and addrErr are all 0.
- R2: A request with reqValid high at a rising edge produces outValid high after that edge; with reqValid low, outValid is low after the edge.
- R3: Mode code 0 (inherent) gives effAddr 0x0000, isImm 0 and instrLen 1, or 2 when a prebyte is present.
- R4: Mode code 1 (immediate) gives isImm 1 and effAddr equal to instrAddr plus 1 plus 1 if a prebyte is present; instrLen adds 2 operand bytes when wideImm is 1 and 1 operand byte otherwise.
- R5: Mode code 2 (direct) gives effAddr with high byte 0x00 and low byte opByte1, and a length of 2 plus the prebyte byte.
- R6: Mode code 3 (extended) gives effAddr {opByte1, opByte2}, opByte1 being the high byte, and a length of 3 plus the prebyte byte.
- R7: Mode code 4 (indexed) gives effAddr equal to idxX plus opByte1 zero-extended, or idxY plus that offset when the prebyte 0x18 is present; length 2 plus the prebyte byte.
- R8: Mode code 5 (relative) gives effAddr equal to instrAddr plus instrLen plus opByte1 sign-extended.
- R9: Prebytes 0x1A and 0xCD are accepted: they add one byte to the length and leave indexed mode on idxX.
- R10: Mode codes 6 and 7 set addrErr and force effAddr, instrLen and isImm to 0.
- R11: A present prebyte other than 0x18, 0x1A or 0xCD sets addrErr with the same zeroed outputs as R10.
- R12: Indexed and relative sums wrap modulo 2^16 with no other effect.
- R13: While reqValid is low, effAddr, instrLen, isImm and addrErr keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; the other inputs are taken when it is high |
| modeCode | input | 3 | Addressing mode: 0 inherent, 1 immediate, 2 direct, 3 extended, 4 indexed, 5 relative |
| hasPrebyte | input | 1 | A prebyte precedes the opcode |
| prebyte | input | 8 | Prebyte value, looked at only when hasPrebyte is 1 |
| opByte1 | input | 8 | First byte after the opcode |
| opByte2 | input | 8 | Second byte after the opcode |
| wideImm | input | 1 | Immediate operand is two bytes |
| idxX | input | 16 | X index register |
| idxY | input | 16 | Y index register |
| instrAddr | input | 16 | Address of the instruction's first byte (prebyte if present) |
| outValid | output | 1 | Result registers were loaded at the last edge |
| effAddr | output | 16 | Operand address |
| isImm | output | 1 | Operand is inside the instruction stream |
| instrLen | output | 3 | Instruction length in bytes |
| addrErr | output | 1 | Invalid mode code or prebyte |

## Verification
The two functions that meet in one cycle are the prebyte decode and the address/length arithmetic: a relative or indexed request carrying a prebyte needs both the lengthened count and the register choice in the same sum, and an illegal prebyte must win over an otherwise legal mode. Requests are sent with each prebyte value combined with indexed, immediate, direct and extended modes, and with one illegal value, and the bench judges the address and length against sums it forms itself, including ones that cross 0xFFFF. Requests that let the relative offset run backward past zero show whether the length feeds the relative sum.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;

  localparam logic [BYTE_W-1:0] PRE_YSEL = 8'h18;
  localparam logic [BYTE_W-1:0] PRE_ALT1 = 8'h1A;
  localparam logic [BYTE_W-1:0] PRE_ALT2 = 8'hCD;

  typedef enum logic [2:0] {
    MODE_INH = 3'd0,
    MODE_IMM = 3'd1,
    MODE_DIR = 3'd2,
    MODE_EXT = 3'd3,
    MODE_IDX = 3'd4,
    MODE_REL = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_STREAM,
    SRC_PAGE0,
    SRC_FULL,
    SRC_INDEX,
    SRC_BRANCH
  } addrSrc_e;

  typedef struct packed {
    addrSrc_e         src;
    logic             useY;
    logic             immFlag;
    logic             fault;
    logic [LEN_W-1:0] len;
    logic [1:0]       streamOfs;
  } ctrlStrobe_t;

endpackage

// File: rtl/opnd_addr_ctrl.sv
module opnd_addr_ctrl
  import opnd_addr_pkg::*;
(
  input  logic [2:0]        modeCode,
  input  logic              hasPrebyte,
  input  logic [BYTE_W-1:0] prebyte,
  input  logic              wideImm,
  output ctrlStrobe_t       strobe
);

  logic       preKnown;
  logic       preBad;
  logic [1:0] preCnt;
  logic [1:0] opndCnt;
  logic       modeBad;

  always_comb begin
    preKnown = (prebyte == PRE_YSEL) || (prebyte == PRE_ALT1) || (prebyte == PRE_ALT2);
    preBad   = hasPrebyte && !preKnown;
    preCnt   = hasPrebyte ? 2'd1 : 2'd0;
  end

  always_comb begin
    modeBad        = 1'b0;
    opndCnt        = 2'd0;
    strobe.src     = SRC_ZERO;
    strobe.immFlag = 1'b0;
    case (modeCode)
      MODE_INH: opndCnt = 2'd0;
      MODE_IMM: begin
        strobe.src     = SRC_STREAM;
        strobe.immFlag = 1'b1;
        opndCnt        = wideImm ? 2'd2 : 2'd1;
      end
      MODE_DIR: begin strobe.src = SRC_PAGE0;  opndCnt = 2'd1; end
      MODE_EXT: begin strobe.src = SRC_FULL;   opndCnt = 2'd2; end
      MODE_IDX: begin strobe.src = SRC_INDEX;  opndCnt = 2'd1; end
      MODE_REL: begin strobe.src = SRC_BRANCH; opndCnt = 2'd1; end
      default:  modeBad = 1'b1;
    endcase

    strobe.fault     = modeBad || preBad;
    strobe.useY      = hasPrebyte && (prebyte == PRE_YSEL);
    strobe.streamOfs = 2'd1 + preCnt;
    strobe.len       = LEN_W'(1) + LEN_W'(preCnt) + LEN_W'(opndCnt);

    if (strobe.fault) begin
      strobe.src     = SRC_ZERO;
      strobe.immFlag = 1'b0;
      strobe.len     = '0;
    end
  end

endmodule

// File: rtl/opnd_addr_dpath.sv
module opnd_addr_dpath
  import opnd_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] opByte1,
  input  logic [BYTE_W-1:0] opByte2,
  input  logic [ADDR_W-1:0] idxX,
  input  logic [ADDR_W-1:0] idxY,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              isImm,
  output logic [LEN_W-1:0]  instrLen,
  output logic              addrErr
);

  localparam int PAD_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] offZext;
  logic [ADDR_W-1:0] offSext;
  logic [ADDR_W-1:0] nextPc;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    baseReg = strobe.useY ? idxY : idxX;
    offZext = {{PAD_W{1'b0}}, opByte1};
    offSext = {{PAD_W{opByte1[BYTE_W-1]}}, opByte1};
    nextPc  = instrAddr + ADDR_W'(strobe.len);
    case (strobe.src)
      SRC_STREAM: addrNext = instrAddr + ADDR_W'(strobe.streamOfs);
      SRC_PAGE0:  addrNext = offZext;
      SRC_FULL:   addrNext = {opByte1, opByte2};
      SRC_INDEX:  addrNext = baseReg + offZext;
      SRC_BRANCH: addrNext = nextPc + offSext;
      default:    addrNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      isImm    <= 1'b0;
      instrLen <= '0;
      addrErr  <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        effAddr  <= addrNext;
        isImm    <= strobe.immFlag;
        instrLen <= strobe.len;
        addrErr  <= strobe.fault;
      end
    end
  end

  // R2: result flag follows the request strobe by one edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R13: registers hold while no request is taken
  a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(effAddr) && $stable(instrLen) && $stable(isImm) && $stable(addrErr)));

  // R10, R11: a faulted result carries no address or length
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (effAddr == '0 && instrLen == '0 && !isImm));

  // R5: page-zero requests leave the high byte clear
  a_r5_page_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strobe.src == SRC_PAGE0) |=> (effAddr[ADDR_W-1:BYTE_W] == '0));

  // R4: stream operand always has at least opcode plus one byte
  a_r4_imm_len: assert property (@(posedge clk) disable iff (!rstN)
    isImm |-> (instrLen >= LEN_W'(2) && !addrErr));

  // R3..R9: a good result is between one and four bytes long
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !addrErr) |-> (instrLen >= LEN_W'(1) && instrLen <= LEN_W'(4)));

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  modeCode,
  input  logic        hasPrebyte,
  input  logic [7:0]  prebyte,
  input  logic [7:0]  opByte1,
  input  logic [7:0]  opByte2,
  input  logic        wideImm,
  input  logic [15:0] idxX,
  input  logic [15:0] idxY,
  input  logic [15:0] instrAddr,
  output logic        outValid,
  output logic [15:0] effAddr,
  output logic        isImm,
  output logic [2:0]  instrLen,
  output logic        addrErr
);

  ctrlStrobe_t strobe;

  opnd_addr_ctrl u_ctrl (
    .modeCode   (modeCode),
    .hasPrebyte (hasPrebyte),
    .prebyte    (prebyte),
    .wideImm    (wideImm),
    .strobe     (strobe)
  );

  opnd_addr_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .strobe    (strobe),
    .opByte1   (opByte1),
    .opByte2   (opByte2),
    .idxX      (idxX),
    .idxY      (idxY),
    .instrAddr (instrAddr),
    .outValid  (outValid),
    .effAddr   (effAddr),
    .isImm     (isImm),
    .instrLen  (instrLen),
    .addrErr   (addrErr)
  );

endmodule

// File: tb/opnd_addr_gen_test.sv
module opnd_addr_gen_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  modeCode = '0;
  logic        hasPrebyte = 1'b0;
  logic [7:0]  prebyte = '0;
  logic [7:0]  opByte1 = '0;
  logic [7:0]  opByte2 = '0;
  logic        wideImm = 1'b0;
  logic [15:0] idxX = '0;
  logic [15:0] idxY = '0;
  logic [15:0] instrAddr = '0;
  logic        outValid;
  logic [15:0] effAddr;
  logic        isImm;
  logic [2:0]  instrLen;
  logic        addrErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_gen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeCode(modeCode),
    .hasPrebyte(hasPrebyte), .prebyte(prebyte), .opByte1(opByte1),
    .opByte2(opByte2), .wideImm(wideImm), .idxX(idxX), .idxY(idxY),
    .instrAddr(instrAddr), .outValid(outValid), .effAddr(effAddr),
    .isImm(isImm), .instrLen(instrLen), .addrErr(addrErr)
  );

  task automatic check(string req, logic [15:0] actA, logic [2:0] actL, logic actI, logic actE, logic actV,
                       logic [15:0] expA, logic [2:0] expL, logic expI, logic expE, logic expV);
    nChecks++;
    if (actA !== expA || actL !== expL || actI !== expI || actE !== expE || actV !== expV) begin
      nFails++;
      $display("FAIL %s: addr=%h len=%0d imm=%b err=%b vld=%b expected addr=%h len=%0d imm=%b err=%b vld=%b",
               req, actA, actL, actI, actE, actV, expA, expL, expI, expE, expV);
    end
  endtask

  // Drive at a falling edge, capture at the next rising edge, sample at the falling edge after it.
  task automatic request(string req, logic [2:0] m, logic hp, logic [7:0] pb, logic [7:0] b1, logic [7:0] b2,
                         logic w, logic [15:0] x, logic [15:0] y, logic [15:0] pc,
                         logic [15:0] expA, logic [2:0] expL, logic expI, logic expE);
    modeCode = m; hasPrebyte = hp; prebyte = pb; opByte1 = b1; opByte2 = b2;
    wideImm = w; idxX = x; idxY = y; instrAddr = pc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, effAddr, instrLen, isImm, addrErr, outValid, expA, expL, expI, expE, 1'b1);
  endtask

  task automatic testReset;
    check("R1", effAddr, instrLen, isImm, addrErr, outValid, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testInherent;
    request("R3", 3'd0, 1'b0, 8'h00, 8'h12, 8'h34, 1'b0, 16'h1111, 16'h2222, 16'h0400, 16'h0000, 3'd1, 1'b0, 1'b0);
    request("R3", 3'd0, 1'b1, 8'h18, 8'h12, 8'h34, 1'b0, 16'h1111, 16'h2222, 16'h0400, 16'h0000, 3'd2, 1'b0, 1'b0);
  endtask

  task automatic testImmediate;
    request("R4", 3'd1, 1'b0, 8'h00, 8'h4A, 8'h00, 1'b0, 16'h0, 16'h0, 16'h1000, 16'h1001, 3'd2, 1'b1, 1'b0);
    request("R4", 3'd1, 1'b1, 8'h18, 8'hD8, 8'h00, 1'b1, 16'h0, 16'h0, 16'h2000, 16'h2002, 3'd4, 1'b1, 1'b0);
    request("R4", 3'd1, 1'b0, 8'h00, 8'hC8, 8'h00, 1'b1, 16'h0, 16'h0, 16'hFFFF, 16'h0000, 3'd3, 1'b1, 1'b0);
  endtask

  task automatic testDirect;
    request("R5", 3'd2, 1'b0, 8'h00, 8'h5B, 8'hAA, 1'b0, 16'h0, 16'h0, 16'h3000, 16'h005B, 3'd2, 1'b0, 1'b0);
    request("R5", 3'd2, 1'b1, 8'h1A, 8'hFF, 8'hAA, 1'b0, 16'h0, 16'h0, 16'h3000, 16'h00FF, 3'd3, 1'b0, 1'b0);
  endtask

  task automatic testExtended;
    request("R6", 3'd3, 1'b0, 8'h00, 8'h6D, 8'h00, 1'b0, 16'h0, 16'h0, 16'h0100, 16'h6D00, 3'd3, 1'b0, 1'b0);
    request("R6", 3'd3, 1'b1, 8'hCD, 8'hB6, 8'h01, 1'b0, 16'h0, 16'h0, 16'h0100, 16'hB601, 3'd4, 1'b0, 1'b0);
  endtask

  task automatic testIndexed;
    request("R7", 3'd4, 1'b0, 8'h00, 8'h56, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0, 16'h1056, 3'd2, 1'b0, 1'b0);
    request("R7", 3'd4, 1'b1, 8'h18, 8'hF0, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0, 16'h20F0, 3'd3, 1'b0, 1'b0);
    request("R9", 3'd4, 1'b1, 8'hCD, 8'h80, 8'h00, 1'b0, 16'h3000, 16'h4000, 16'h0, 16'h3080, 3'd3, 1'b0, 1'b0);
    request("R9", 3'd4, 1'b1, 8'h1A, 8'h01, 8'h00, 1'b0, 16'h3000, 16'h4000, 16'h0, 16'h3001, 3'd3, 1'b0, 1'b0);
    request("R12", 3'd4, 1'b0, 8'h00, 8'h20, 8'h00, 1'b0, 16'hFFF0, 16'h0, 16'h0, 16'h0010, 3'd2, 1'b0, 1'b0);
  endtask

  task automatic testRelative;
    request("R8", 3'd5, 1'b0, 8'h00, 8'hF0, 8'h00, 1'b0, 16'h0, 16'h0, 16'h0010, 16'h0002, 3'd2, 1'b0, 1'b0);
    request("R8", 3'd5, 1'b0, 8'h00, 8'h7F, 8'h00, 1'b0, 16'h0, 16'h0, 16'h1000, 16'h1081, 3'd2, 1'b0, 1'b0);
    request("R12", 3'd5, 1'b0, 8'h00, 8'h05, 8'h00, 1'b0, 16'h0, 16'h0, 16'hFFFE, 16'h0005, 3'd2, 1'b0, 1'b0);
    request("R12", 3'd5, 1'b0, 8'h00, 8'h80, 8'h00, 1'b0, 16'h0, 16'h0, 16'h0000, 16'hFF82, 3'd2, 1'b0, 1'b0);
    request("R8", 3'd5, 1'b1, 8'h1A, 8'hFE, 8'h00, 1'b0, 16'h0, 16'h0, 16'h0200, 16'h0201, 3'd3, 1'b0, 1'b0);
  endtask

  task automatic testFaults;
    request("R10", 3'd6, 1'b0, 8'h00, 8'h12, 8'h34, 1'b1, 16'h1234, 16'h0, 16'h5000, 16'h0000, 3'd0, 1'b0, 1'b1);
    request("R10", 3'd7, 1'b1, 8'h18, 8'h12, 8'h34, 1'b0, 16'h1234, 16'h0, 16'h5000, 16'h0000, 3'd0, 1'b0, 1'b1);
    request("R11", 3'd2, 1'b1, 8'h55, 8'h12, 8'h34, 1'b0, 16'h0, 16'h0, 16'h5000, 16'h0000, 3'd0, 1'b0, 1'b1);
    request("R11", 3'd1, 1'b1, 8'h19, 8'h12, 8'h34, 1'b0, 16'h0, 16'h0, 16'h5000, 16'h0000, 3'd0, 1'b0, 1'b1);
  endtask

  task automatic testHold;
    request("R2", 3'd3, 1'b0, 8'h00, 8'hAB, 8'hCD, 1'b0, 16'h0, 16'h0, 16'h0, 16'hABCD, 3'd3, 1'b0, 1'b0);
    modeCode = 3'd6; opByte1 = 8'h01; opByte2 = 8'h02; instrAddr = 16'h7777; hasPrebyte = 1'b1; prebyte = 8'h99;
    @(negedge clk);
    check("R13", effAddr, instrLen, isImm, addrErr, outValid, 16'hABCD, 3'd3, 1'b0, 1'b0, 1'b0);
    modeCode = 3'd1;
    @(negedge clk);
    check("R13", effAddr, instrLen, isImm, addrErr, outValid, 16'hABCD, 3'd3, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInherent();
    testImmediate();
    testDirect();
    testExtended();
    testIndexed();
    testRelative();
    testFaults();
    testHold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule